// File: doc/BRIEF.md
# Interleaved Parallel Key Search Dispatcher

The dispatcher coordinates a parameterised number of identical key trial cores that search a key space of configurable width. The trial logic is outside this block. When a search is launched, every core starts at once, and core `c` starts on key `c`. Each time a core reports a trial without a match, the dispatcher gives it its previous key plus the core count. This spreads the key space across the cores by stride, not in contiguous blocks.

The first reported match from any active core ends the search. All cores are stopped, and the matching key and the index of the core that tried it are latched. If every core has run past the top of the key space with no match, an exhausted flag is raised instead. An abort input returns the dispatcher and every core to idle in one cycle. Done and match reports that arrive after a core has been stopped are ignored.

Top module: `key_search_dispatch`

## Requirements
- R1: After reset the block is idle: `busy`, `found`, `exhausted` and every `core_go` bit are 0.
- R2: When `start` is high while idle and `abort` is low, in the next cycle `busy` is 1, `found` and `exhausted` are 0, and every core whose index fits in the key space pulses `core_go` for one cycle with its key slice (bits `[c*KEY_W +: KEY_W]`) equal to `c`.
- R3: Over a search, core `c` tries only keys congruent to `c` modulo `NUM_CORES`. In a run with no match, every key from 0 to 2^KEY_W-1 is tried exactly once.
- R4: When an active core reports `core_done` without `core_hit`, it pulses `core_go` in the next cycle with its previous key plus `NUM_CORES`. If that sum would exceed 2^KEY_W-1, the core retires instead and is not started again.
- R5: When an active core reports `core_done` with `core_hit`, in the next cycle `found` is 1, `busy` is 0, no `core_go` is pulsed, and `win_key`/`win_core` hold that core's key and index.
- R6: If several active cores report a match in the same cycle, the one with the lowest index wins.
- R7: When the last active core retires with no match, `exhausted` rises in the next cycle and `busy` falls. `found` and `exhausted` are never both 1.
- R8: `abort` while busy makes `busy` 0 in the next cycle, with no `core_go` and with `found` and `exhausted` both 0. Later done or match reports from the cores have no effect.
- R9: `win_key`, `win_core`, `found` and `exhausted` stay unchanged from the end of a search until the next accepted `start`. `start` while busy, and done/match reports while idle, are ignored.
- R10: The key 2^KEY_W-1 at the top of the space is tried and can be reported as the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a search (ignored while busy) |
| abort | input | 1 | Stop the running search and return to idle |
| core_done | input | NUM_CORES | Per-core trial-finished pulse |
| core_hit | input | NUM_CORES | Per-core match flag, valid with `core_done` |
| core_go | output | NUM_CORES | Per-core one-cycle trial start pulse |
| core_key | output | NUM_CORES*KEY_W | Per-core key to try, core `c` in bits `[c*KEY_W +: KEY_W]` |
| busy | output | 1 | A search is running |
| found | output | 1 | The last search ended on a match |
| exhausted | output | 1 | The last search covered the whole space with no match |
| win_key | output | KEY_W | Key that matched |
| win_core | output | CORE_IDX_W | Index of the core that matched |

## Verification
Every cycle, the assertions check that trial pulses occur only while busy, that a match stops all cores at once, that abort clears the run, that the two end flags never coincide, and that the result registers do not move while idle. Only the bench scenarios can show the key arithmetic. These scenarios cover the stride sequence per core, each key tried exactly once, the winner's key and index for every possible single target in a small configuration, lowest-index arbitration between simultaneous matches, and the exact cycle on which `found` or `exhausted` appears.

// File: rtl/ksd_pkg.sv
package ksd_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Width of an index able to name n items (at least one bit).
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ksd_lane.sv
// One per core: holds the core's current key, steps it by the core count.
module ksd_lane #(
    parameter int unsigned KEY_W  = 24,
    parameter int unsigned STRIDE = 108,
    parameter int unsigned INDEX  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             stop,
    input  logic             done,
    output logic [KEY_W-1:0] key,
    output logic             active,
    output logic             go,
    output logic             retire
);
    localparam bit IN_RANGE = (longint'(INDEX) < (longint'(1) << KEY_W));

    logic [KEY_W-1:0] key_q;
    logic             active_q;
    logic             go_q;
    logic [KEY_W:0]   nxt;

    assign nxt    = {1'b0, key_q} + (KEY_W+1)'(STRIDE);
    assign retire = active_q & done & nxt[KEY_W];

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            active_q <= 1'b0;
            go_q     <= 1'b0;
        end else if (launch) begin
            active_q <= IN_RANGE;
            go_q     <= IN_RANGE;
        end else if (active_q && done) begin
            active_q <= ~nxt[KEY_W];
            go_q     <= ~nxt[KEY_W];
        end else begin
            go_q     <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
        end else if (!stop && launch) begin
            key_q <= KEY_W'(INDEX);
        end else if (!stop && active_q && done && !nxt[KEY_W]) begin
            key_q <= nxt[KEY_W-1:0];
        end
    end

    assign key    = key_q;
    assign active = active_q;
    assign go     = go_q;
endmodule

// File: rtl/ksd_pick.sv
// Lowest-index-first selection among simultaneous match reports.
module ksd_pick #(
    parameter int unsigned N     = 108,
    parameter int unsigned IDX_W = 7
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/ksd_ctrl.sv
// Run/idle phase, end-of-search decision and result latches.
module ksd_ctrl
    import ksd_pkg::*;
#(
    parameter int unsigned KEY_W = 24,
    parameter int unsigned IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             hit_any,
    input  logic             any_left,
    input  logic [KEY_W-1:0] hit_key,
    input  logic [IDX_W-1:0] hit_idx,
    output logic             launch,
    output logic             stop,
    output logic             busy,
    output logic             found,
    output logic             exhausted,
    output logic [KEY_W-1:0] win_key,
    output logic [IDX_W-1:0] win_core
);
    phase_e           phase_q;
    logic             found_q, exh_q;
    logic [KEY_W-1:0] wkey_q;
    logic [IDX_W-1:0] wcore_q;
    logic             run;

    assign run    = (phase_q == PH_RUN);
    assign launch = start & ~abort & ~run;
    assign stop   = abort | (run & hit_any);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            found_q <= 1'b0;
            exh_q   <= 1'b0;
            wkey_q  <= '0;
            wcore_q <= '0;
        end else if (launch) begin
            phase_q <= PH_RUN;
            found_q <= 1'b0;
            exh_q   <= 1'b0;
        end else if (run) begin
            if (abort) begin
                phase_q <= PH_IDLE;
            end else if (hit_any) begin
                phase_q <= PH_IDLE;
                found_q <= 1'b1;
                wkey_q  <= hit_key;
                wcore_q <= hit_idx;
            end else if (!any_left) begin
                phase_q <= PH_IDLE;
                exh_q   <= 1'b1;
            end
        end
    end

    assign busy      = run;
    assign found     = found_q;
    assign exhausted = exh_q;
    assign win_key   = wkey_q;
    assign win_core  = wcore_q;
endmodule

// File: rtl/key_search_dispatch.sv
module key_search_dispatch
    import ksd_pkg::*;
#(
    parameter  int unsigned NUM_CORES  = 108,
    parameter  int unsigned KEY_W      = 24,
    localparam int unsigned CORE_IDX_W = idx_bits(NUM_CORES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       abort,
    input  logic [NUM_CORES-1:0]       core_done,
    input  logic [NUM_CORES-1:0]       core_hit,
    output logic [NUM_CORES-1:0]       core_go,
    output logic [NUM_CORES*KEY_W-1:0] core_key,
    output logic                       busy,
    output logic                       found,
    output logic                       exhausted,
    output logic [KEY_W-1:0]           win_key,
    output logic [CORE_IDX_W-1:0]      win_core
);
    logic [KEY_W-1:0]      lane_key [NUM_CORES];
    logic [NUM_CORES-1:0]  lane_act, lane_ret;
    logic                  launch, stop, hit_any;
    logic [CORE_IDX_W-1:0] hit_idx;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
        ksd_lane #(
            .KEY_W (KEY_W),
            .STRIDE(NUM_CORES),
            .INDEX (c)
        ) lane_i (
            .clk   (clk),
            .rst   (rst),
            .launch(launch),
            .stop  (stop),
            .done  (core_done[c]),
            .key   (lane_key[c]),
            .active(lane_act[c]),
            .go    (core_go[c]),
            .retire(lane_ret[c])
        );
        assign core_key[c*KEY_W +: KEY_W] = lane_key[c];
    end

    ksd_pick #(
        .N    (NUM_CORES),
        .IDX_W(CORE_IDX_W)
    ) pick_i (
        .req(core_done & core_hit & lane_act),
        .any(hit_any),
        .idx(hit_idx)
    );

    ksd_ctrl #(
        .KEY_W(KEY_W),
        .IDX_W(CORE_IDX_W)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .abort    (abort),
        .hit_any  (hit_any),
        .any_left (|(lane_act & ~lane_ret)),
        .hit_key  (lane_key[hit_idx]),
        .hit_idx  (hit_idx),
        .launch   (launch),
        .stop     (stop),
        .busy     (busy),
        .found    (found),
        .exhausted(exhausted),
        .win_key  (win_key),
        .win_core (win_core)
    );
endmodule

// File: rtl/ksd_checker.sv
module ksd_checker #(
    parameter int unsigned N     = 108,
    parameter int unsigned KEY_W = 24,
    parameter int unsigned IDX_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             abort,
    input logic [N-1:0]     core_go,
    input logic             busy,
    input logic             found,
    input logic             exhausted,
    input logic [KEY_W-1:0] win_key,
    input logic [IDX_W-1:0] win_core
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) $fell(rst) |-> (!busy && !found && !exhausted && core_go == '0)); // R1
    AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> ($past(start) && core_go[0] && !found && !exhausted)); // R2
    AST_GO_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst) (|core_go) |-> busy); // R8
    AST_MATCH_HALTS_ALL: assert property (@(posedge clk) disable iff (rst) $rose(found) |-> (!busy && core_go == '0)); // R5
    AST_END_FLAGS_APART: assert property (@(posedge clk) disable iff (rst) !(found && exhausted)); // R7
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst) (busy && abort) |=> (!busy && core_go == '0 && !found && !exhausted)); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> ($stable(win_key) && $stable(win_core) && $stable(found) && $stable(exhausted))); // R9
endmodule

bind key_search_dispatch ksd_checker #(
    .N    (NUM_CORES),
    .KEY_W(KEY_W),
    .IDX_W(CORE_IDX_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .abort    (abort),
    .core_go  (core_go),
    .busy     (busy),
    .found    (found),
    .exhausted(exhausted),
    .win_key  (win_key),
    .win_core (win_core)
);

// File: tb/key_search_dispatch_tb_top.sv
module key_search_dispatch_tb_top;
    localparam int N   = 5;
    localparam int KW  = 6;
    localparam int SP  = 1 << KW;
    localparam int IW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, abort = 1'b0;
    logic [N-1:0]  done_m, hit_m, extra_done, extra_hit;
    logic [N-1:0]  core_go;
    logic [N*KW-1:0] core_key;
    logic          busy, found, exhausted;
    logic [KW-1:0] win_key;
    logic [IW-1:0] win_core;

    logic [SP-1:0] tgt_mask = '0;
    logic          clr = 1'b0;
    int            tries [SP];
    int            expk [N];
    int            bad_seq, go_total;
    int            n_chk = 0, n_bad = 0, cyc_total = 0;

    always #4 clk = ~clk;

    key_search_dispatch #(.NUM_CORES(N), .KEY_W(KW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .core_done(done_m | extra_done), .core_hit(hit_m | extra_hit),
        .core_go(core_go), .core_key(core_key), .busy(busy), .found(found),
        .exhausted(exhausted), .win_key(win_key), .win_core(win_core)
    );

    // Core models: report one cycle after a go, and record every key tried.
    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        for (int c = 0; c < N; c++) begin
            done_m[c] <= core_go[c];
            hit_m[c]  <= core_go[c] && tgt_mask[core_key[c*KW +: KW]];
        end
        if (clr) begin
            for (int k = 0; k < SP; k++) tries[k] <= 0;
            for (int c = 0; c < N; c++) expk[c] <= c;
            bad_seq <= 0;
        end else begin
            for (int c = 0; c < N; c++) begin
                if (core_go[c]) begin
                    tries[core_key[c*KW +: KW]] <= tries[core_key[c*KW +: KW]] + 1;
                    if (int'(core_key[c*KW +: KW]) != expk[c]) bad_seq <= bad_seq + 1;
                    expk[c] <= int'(core_key[c*KW +: KW]) + N;
                end
            end
        end
        if (core_go != '0) go_total <= go_total + 1;
    end

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    // Launch, optionally pulse start again mid-run, return cycles to the end flag.
    task automatic run_search(input int mid_start, output int cyc);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (!(found || exhausted) && cyc < 300) begin
            @(negedge clk);
            cyc++;
            start = (cyc == mid_start);
        end
        start = 1'b0;
    endtask

    function automatic int tried_count();
        int s = 0;
        for (int k = 0; k < SP; k++) s += (tries[k] != 0) ? 1 : 0;
        return s;
    endfunction

    function automatic bit once_below(input int lim);
        for (int k = 0; k < SP; k++)
            if (tries[k] != ((k < lim) ? 1 : 0)) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        int cyc, lim, wk, wc, g0;
        extra_done = '0;
        extra_hit  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !found && !exhausted && core_go == '0, "R1 idle after reset", busy, 0);

        // Start: all cores go with key = index.
        clear_log();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && core_go == '1, "R2 launch pulses all cores", core_go, 5'h1f);
        for (int c = 0; c < N; c++)
            chk(int'(core_key[c*KW +: KW]) == c, "R2 first key equals index", core_key[c*KW +: KW], c);
        while (busy) @(negedge clk);

        // Sweep every single target.
        for (int t = 0; t < SP; t++) begin
            tgt_mask = '0;
            tgt_mask[t] = 1'b1;
            clear_log();
            run_search(0, cyc);
            lim = (t / N + 1) * N;
            if (lim > SP) lim = SP;
            chk(found && !exhausted && !busy, "R5 match ends search", found, 1);
            chk(int'(win_key) == t, (t == SP-1) ? "R10 top key wins" : "R5 winning key", win_key, t);
            chk(int'(win_core) == t % N, "R5 winning core", win_core, t % N);
            chk(cyc == 2 * (t / N) + 2, "R5 found timing", cyc, 2 * (t / N) + 2);
            chk(once_below(lim), "R3 keys tried once up to round end", tried_count(), lim);
            chk(bad_seq == 0, "R4 stride sequence per core", bad_seq, 0);
        end

        // Simultaneous matches: lowest index wins; earlier round beats lower index.
        tgt_mask = '0; tgt_mask[7] = 1'b1; tgt_mask[8] = 1'b1;
        clear_log(); run_search(0, cyc);
        chk(win_key == 7 && win_core == 2, "R6 same-cycle lowest index", win_key, 7);
        tgt_mask = '0; tgt_mask[9] = 1'b1; tgt_mask[10] = 1'b1;
        clear_log(); run_search(0, cyc);
        chk(win_key == 9 && win_core == 4, "R6 earlier round wins", win_key, 9);
        tgt_mask = '0; tgt_mask[1] = 1'b1; tgt_mask[3] = 1'b1; tgt_mask[4] = 1'b1;
        clear_log(); run_search(0, cyc);
        chk(win_key == 1 && win_core == 1, "R6 three-way same cycle", win_key, 1);

        // Result held while idle; stray reports ignored.
        wk = win_key; wc = win_core; g0 = go_total;
        @(negedge clk) begin extra_done = '1; extra_hit = '1; end
        @(negedge clk) begin extra_done = '0; extra_hit = '0; end
        repeat (5) @(negedge clk);
        chk(found && !busy && int'(win_key) == wk && int'(win_core) == wc && go_total == g0,
            "R9 result held, idle reports ignored", win_key, wk);

        // No match: exhausted, every key once, start while busy ignored.
        tgt_mask = '0;
        clear_log(); run_search(7, cyc);
        chk(exhausted && !found && !busy, "R7 exhausted flag", exhausted, 1);
        chk(cyc == 2 * ((SP + N - 1) / N), "R7 exhausted timing", cyc, 2 * ((SP + N - 1) / N));
        chk(once_below(SP), "R3 full space tried once", tried_count(), SP);
        chk(tries[SP-1] == 1, "R10 top key tried", tries[SP-1], 1);
        chk(bad_seq == 0, "R9 start while busy ignored", bad_seq, 0);

        // Abort mid-run.
        clear_log();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        chk(!busy && core_go == '0 && !found && !exhausted, "R8 abort returns to idle", busy, 0);
        g0 = go_total;
        repeat (8) @(negedge clk);
        chk(go_total == g0 && !busy && !found && !exhausted, "R8 late reports ignored", go_total, g0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc_total > 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule